// File: doc/BRIEF.md
# SPI Master Single-Word Transfer Controller

This block is the master side of a single-word serial peripheral link. A start pulse hands it a parallel transmit word, a word length and a bit-rate setting. It pulls the chip select low and clocks the word out most significant bit first. It captures the incoming serial line on every rising serial-clock edge, then releases chip select and pulses a done flag for one cycle. The received bits are then on a parallel output.

The transfer is run by an explicit four-state machine: idle, load, shift and done. The load state places the transmit word in a shift register. The shift state runs until a bit counter reaches the word length that was captured at start. Everything runs on the system clock. The serial clock comes from a programmable divider enable, not from a second clock. A watchdog returns the machine to idle when no divider enable arrives for a fixed number of cycles during a transfer. The state register is one-hot, and any encoding outside the four legal ones falls back to idle.

Top module: `spi_xfer_master`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), cs_n is 1, and sclk, mosi, done and rx_word are all 0.
- R2: A start seen high at a clock edge while idle captures tx_word, word_len and half_period. cs_n is 0 in the cycle after that edge and stays low until the done cycle.
- R3: The serial clock idles low (SPI mode 0). Exactly L rising sclk edges occur per completed transfer, where L is the effective length. mosi carries bit L-1 of tx_word down to bit 0, and changes only while sclk is low. Bits of tx_word at L and above are not sent.
- R4: Every high phase and every low phase of sclk between consecutive sclk edges lasts exactly half_period system-clock cycles.
- R5: miso is sampled at each rising sclk edge. At done, rx_word holds the L received bits right-aligned, with the first bit received at bit L-1 and bits L and above zero. rx_word keeps this value until the next accepted start.
- R6: done is high for exactly one cycle per completed transfer. In that cycle cs_n is already 1, and the machine is idle again in the next cycle.
- R7: The effective length L is word_len clamped to the range 4 to 32: a word_len below 4 gives 4 and a word_len above 32 gives 32.
- R8: start is ignored unless the machine is idle. Changes to start, tx_word or word_len during a transfer do not alter the transfer in progress.
- R9: If no divider enable occurs for TIMEOUT_CYCLES consecutive cycles in the shift state, the machine returns to idle without a done pulse. A half_period of 0 produces no enables. cs_n is 1 one cycle after the TIMEOUT_CYCLES-th shift cycle with no enable. The next start then runs a normal transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Transfer request, honoured only in idle |
| tx_word | input | MAX_LEN | Word to send, right-aligned |
| word_len | input | LEN_W | Requested bit count, clamped to MIN_LEN..MAX_LEN |
| half_period | input | DIV_W | System cycles per sclk half period (0 = no enable) |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the slave, MSB first |
| rx_word | output | MAX_LEN | Received word, right-aligned |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with MAX_LEN 32, a 3-bit divider field and TIMEOUT_CYCLES 20. This keeps even 32-bit transfers at half period 7 short. The bench can therefore sweep every legal word length against half periods 1, 2, 3 and 7. A behavioural slave checks each sent bit and the received word. The short timeout keeps the stalled case with half_period 0 a few dozen cycles long, so its exact exit cycle can be checked. The 6-bit length field makes values below and above the clamp limits reachable.

// File: rtl/spi_xfer_pkg.sv
// Package: shared state type for the SPI transfer controller.
// Assumes a one-hot state register; every other encoding is treated as illegal.
package spi_xfer_pkg;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'b0001,
        ST_LOAD  = 4'b0010,
        ST_SHIFT = 4'b0100,
        ST_DONE  = 4'b1000
    } xfer_state_t;

endpackage

// File: rtl/spi_tick_gen.sv
// Module: spi_tick_gen
// Produces a one-cycle enable every half_period cycles while run is high.
// Assumes half_period is held stable during a run; a value of 0 yields no enable.
module spi_tick_gen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_period,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    // Terminal count detect; zero setting never wraps.
    always_comb begin
        wrap = (half_period != '0) && (cnt_q == half_period - 1'b1);
    end

    assign tick = run && wrap;

    // Cycle counter, cleared when not running or on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // No enable is ever produced with a zero divider setting.
    p_no_tick_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (half_period == '0) |-> !tick);

endmodule

// File: rtl/spi_bit_engine.sv
// Module: spi_bit_engine
// Holds the transmit shift register, receive register, serial clock phase
// and bit counter. Rising phase samples miso; falling phase advances data.
// Assumes len is between 1 and MAX_LEN and stable from load to end of shift.
module spi_bit_engine #(
    parameter int MAX_LEN = 32,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               active,
    input  logic               tick,
    input  logic [MAX_LEN-1:0] tx_word,
    input  logic [LEN_W-1:0]   len,
    input  logic               miso,
    output logic               sclk_q,
    output logic               mosi_bit,
    output logic [MAX_LEN-1:0] rx_q,
    output logic               last_fall
);

    logic [MAX_LEN-1:0] sr_q;
    logic [LEN_W-1:0]   bit_cnt_q;
    logic [LEN_W-1:0]   align;

    // Left shift that puts bit len-1 of the word at the register MSB.
    always_comb begin
        align = LEN_W'(MAX_LEN) - len;
    end

    assign mosi_bit  = sr_q[MAX_LEN-1];
    assign last_fall = tick && sclk_q && (bit_cnt_q == len - 1'b1);

    // Serial clock phase and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || load || !active) begin
            sclk_q    <= 1'b0;
            bit_cnt_q <= '0;
        end else if (tick) begin
            sclk_q <= !sclk_q;
            if (sclk_q && !last_fall) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
        end
    end

    // Transmit shift register: loaded aligned, shifted on falling phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= tx_word << align;
        end else if (active && tick && sclk_q && !last_fall) begin
            sr_q <= {sr_q[MAX_LEN-2:0], 1'b0};
        end
    end

    // Receive register: cleared on load, fills from the LSB on rising phase.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            rx_q <= '0;
        end else if (active && tick && !sclk_q) begin
            rx_q <= {rx_q[MAX_LEN-2:0], miso};
        end
    end

    // Outgoing data bit does not move across a rising serial clock edge.
    p_mosi_stable_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_q) |-> $stable(mosi_bit));

    // The bit counter never passes the configured length.
    p_bitcnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (bit_cnt_q < len));

endmodule

// File: rtl/spi_xfer_fsm.sv
// Module: spi_xfer_fsm
// Idle/load/shift/done sequencer with a no-enable watchdog in shift.
// Assumes TIMEOUT_CYCLES is larger than the largest half period used.
module spi_xfer_fsm
    import spi_xfer_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 64,
    parameter int WD_W           = $clog2(TIMEOUT_CYCLES + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        tick,
    input  logic        last_fall,
    output xfer_state_t state_q
);

    xfer_state_t     state_d;
    logic [WD_W-1:0] wd_q;
    logic            expire;

    // Watchdog limit reached with no enable in this cycle.
    always_comb begin
        expire = (state_q == ST_SHIFT) && !tick && (wd_q == WD_W'(TIMEOUT_CYCLES - 1));
    end

    // Next-state selection; illegal encodings fall back to idle.
    always_comb begin
        case (state_q)
            ST_IDLE:  state_d = start ? ST_LOAD : ST_IDLE;
            ST_LOAD:  state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (last_fall) begin
                    state_d = ST_DONE;
                end else if (expire) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_SHIFT;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Watchdog: counts shift cycles since the last enable.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_SHIFT || tick) begin
            wd_q <= '0;
        end else begin
            wd_q <= wd_q + 1'b1;
        end
    end

    // Done lasts one cycle and is followed by idle.
    p_done_then_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q == ST_IDLE));

    // An expired watchdog sends the machine to idle.
    p_timeout_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !last_fall) |=> (state_q == ST_IDLE));

    // The state register always holds exactly one legal state.
    p_state_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state_q));

endmodule

// File: rtl/spi_xfer_master.sv
// Module: spi_xfer_master
// Single-word SPI mode 0 master: captures a request, sequences the transfer
// and drives chip select, serial clock and data. Assumes one slave and a
// synchronous active-low reset; all logic is in the clk domain.
module spi_xfer_master
    import spi_xfer_pkg::*;
#(
    parameter int MAX_LEN        = 32,
    parameter int MIN_LEN        = 4,
    parameter int DIV_W          = 4,
    parameter int TIMEOUT_CYCLES = 64,
    parameter int LEN_W          = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [MAX_LEN-1:0] tx_word,
    input  logic [LEN_W-1:0]   word_len,
    input  logic [DIV_W-1:0]   half_period,
    input  logic               miso,
    output logic               cs_n,
    output logic               sclk,
    output logic               mosi,
    output logic [MAX_LEN-1:0] rx_word,
    output logic               done
);

    xfer_state_t        state_q;
    logic               st_idle;
    logic               st_load;
    logic               st_shift;
    logic               accept;
    logic [MAX_LEN-1:0] tx_q;
    logic [LEN_W-1:0]   len_q;
    logic [LEN_W-1:0]   len_eff;
    logic [DIV_W-1:0]   hp_q;
    logic               tick;
    logic               sclk_q;
    logic               mosi_bit;
    logic               last_fall;

    assign st_idle  = (state_q == ST_IDLE);
    assign st_load  = (state_q == ST_LOAD);
    assign st_shift = (state_q == ST_SHIFT);
    assign accept   = start && st_idle;

    // Length clamp to the supported range.
    always_comb begin
        if (word_len < LEN_W'(MIN_LEN)) begin
            len_eff = LEN_W'(MIN_LEN);
        end else if (word_len > LEN_W'(MAX_LEN)) begin
            len_eff = LEN_W'(MAX_LEN);
        end else begin
            len_eff = word_len;
        end
    end

    // Request capture, only on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q  <= '0;
            len_q <= LEN_W'(MIN_LEN);
            hp_q  <= '0;
        end else if (accept) begin
            tx_q  <= tx_word;
            len_q <= len_eff;
            hp_q  <= half_period;
        end
    end

    spi_xfer_fsm #(
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tick     (tick),
        .last_fall(last_fall),
        .state_q  (state_q)
    );

    spi_tick_gen #(
        .DIV_W(DIV_W)
    ) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (st_shift),
        .half_period(hp_q),
        .tick       (tick)
    );

    spi_bit_engine #(
        .MAX_LEN(MAX_LEN),
        .LEN_W  (LEN_W)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (st_load),
        .active   (st_shift),
        .tick     (tick),
        .tx_word  (tx_q),
        .len      (len_q),
        .miso     (miso),
        .sclk_q   (sclk_q),
        .mosi_bit (mosi_bit),
        .rx_q     (rx_word),
        .last_fall(last_fall)
    );

    assign cs_n = !(st_load || st_shift);
    assign sclk = sclk_q && st_shift;
    assign mosi = cs_n ? 1'b0 : mosi_bit;
    assign done = (state_q == ST_DONE);

    // A request arriving mid-transfer leaves the captured request alone.
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !st_idle) |=> ($stable(tx_q) && $stable(len_q)));

    // Chip select is released when done is flagged.
    p_cs_released_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);

    // Captured length always lies in the supported range.
    p_len_clamped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q >= LEN_W'(MIN_LEN)) && (len_q <= LEN_W'(MAX_LEN)));

endmodule

// File: tb/spi_xfer_master_bench.sv
module spi_xfer_master_bench;

    localparam int MAX_LEN = 32;
    localparam int LEN_W   = 6;
    localparam int DIV_W   = 3;
    localparam int TMO     = 20;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [MAX_LEN-1:0] tx_word = '0;
    logic [LEN_W-1:0]   word_len = '0;
    logic [DIV_W-1:0]   half_period = '0;
    logic               miso;
    logic               cs_n;
    logic               sclk;
    logic               mosi;
    logic [MAX_LEN-1:0] rx_word;
    logic               done;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    logic [31:0] slave_w = '0;
    int          cur_len = 4;
    int          idx = 0;
    logic [31:0] cap = '0;
    int          rises = 0;
    int          exp_hp = 1;
    bit          seen_edge = 0;
    int          gap = 0;
    bit          gap_err = 0;
    logic        sclk_prev = 1'b0;

    always #4 clk = !clk;

    spi_xfer_master #(
        .MAX_LEN(MAX_LEN),
        .MIN_LEN(4),
        .DIV_W(DIV_W),
        .TIMEOUT_CYCLES(TMO),
        .LEN_W(LEN_W)
    ) u_spi_xfer_master (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
        .word_len(word_len), .half_period(half_period), .miso(miso),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .rx_word(rx_word), .done(done)
    );

    // Behavioural slave: presents bits MSB first, advances on falling sclk.
    assign miso = (idx < cur_len) ? slave_w[cur_len - 1 - idx] : 1'b0;
    always @(negedge sclk) idx = idx + 1;
    always @(posedge sclk) begin
        cap   = {cap[30:0], mosi};
        rises = rises + 1;
    end

    // Half-period measurement between consecutive sclk edges.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (sclk != sclk_prev) begin
            if (seen_edge && gap != exp_hp) gap_err = 1;
            seen_edge = 1;
            gap = 1;
        end else begin
            gap = gap + 1;
        end
        sclk_prev = sclk;
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: act=%0d exp<=150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] lmask(input int l);
        return (l >= 32) ? 32'hFFFF_FFFF : ((32'h1 << l) - 32'h1);
    endfunction

    task automatic do_xfer(input logic [31:0] tx, input int lin, input int hp,
                           input logic [31:0] sw, input int leff, input bit poke);
        int   waited;
        bit   got;
        @(negedge clk);
        slave_w   = sw;
        cur_len   = leff;
        idx       = 0;
        cap       = '0;
        rises     = 0;
        exp_hp    = hp;
        seen_edge = 0;
        gap_err   = 0;
        tx_word     = tx;
        word_len    = LEN_W'(lin);
        half_period = DIV_W'(hp);
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cs_n == 1'b0, "R2 cs low after start", {31'b0, cs_n}, 32'h0);
        if (poke) begin
            repeat (3) @(negedge clk);
            tx_word  = ~tx;
            word_len = LEN_W'(5);
            start    = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        got = 0;
        while (!got && waited < 2000) begin
            if (done) got = 1;
            else begin
                @(negedge clk);
                waited = waited + 1;
            end
        end
        chk(got && cs_n, "R6 done seen with cs high", {30'b0, got, cs_n}, 32'h3);
        chk(cap == (tx & lmask(leff)), poke ? "R8 R3 mosi word" : "R3 mosi word", cap, tx & lmask(leff));
        chk(rises == leff, "R3 rise count", rises, leff);
        chk(rx_word == (sw & lmask(leff)), "R5 rx word", rx_word, sw & lmask(leff));
        chk(!gap_err, "R4 half period", {31'b0, gap_err}, 32'h0);
        @(negedge clk);
        chk(done == 1'b0 && cs_n == 1'b1, "R6 single done", {30'b0, done, cs_n}, 32'h1);
        chk(rx_word == (sw & lmask(leff)), "R5 rx held", rx_word, sw & lmask(leff));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n reset", {31'b0, cs_n}, 32'h1);
        chk(sclk == 1'b0 && mosi == 1'b0 && done == 1'b0, "R1 sclk mosi done reset",
            {29'b0, sclk, mosi, done}, 32'h0);
        chk(rx_word == '0, "R1 rx reset", rx_word, 32'h0);
        rst_n = 1'b1;

        // Sweep every legal length against several half periods.
        for (int l = 4; l <= 32; l++) begin
            for (int k = 0; k < 4; k++) begin
                int hp;
                logic [31:0] tx;
                logic [31:0] sw;
                hp = (k == 3) ? 7 : k + 1;
                tx = 32'hA5C3_0F96 ^ (32'(l) * 32'h0101_0101) ^ (32'(k) << 7);
                sw = 32'h3C96_E1D2 + (32'(l) * 32'h0003_1337) + 32'(k * 17);
                do_xfer(tx, l, hp, sw, l, (l % 5 == 0) && (k == 1));
            end
        end

        // R7 clamp cases.
        do_xfer(32'hFFFF_FFF9, 0, 2, 32'h0000_000B, 4, 0);
        do_xfer(32'h1234_5676, 2, 1, 32'h0000_0005, 4, 0);
        do_xfer(32'h8000_0001, 33, 1, 32'hDEAD_BEEF, 32, 0);
        do_xfer(32'h7FFF_FFFE, 63, 2, 32'h0F0F_1234, 32, 0);

        // R9 timeout with no divider enable.
        @(negedge clk);
        tx_word     = 32'hFFFF_FFFF;
        word_len    = LEN_W'(8);
        half_period = '0;
        start       = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        begin
            bit saw_done;
            saw_done = 0;
            for (int c = 0; c < TMO; c++) begin
                @(posedge clk);
                #1 if (done) saw_done = 1;
            end
            chk(cs_n == 1'b0, "R9 still busy before limit", {31'b0, cs_n}, 32'h0);
            @(posedge clk);
            #1 if (done) saw_done = 1;
            chk(cs_n == 1'b1, "R9 idle after limit", {31'b0, cs_n}, 32'h1);
            chk(!saw_done, "R9 no done on timeout", {31'b0, saw_done}, 32'h0);
        end
        do_xfer(32'h0000_00A7, 8, 3, 32'h0000_005C, 8, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule